// File: doc/BRIEF.md
# Queue-Pair Channel Controller

This block holds the control and status side of a group of memory-to-memory copy channels. Each channel owns a small window of 32-bit registers, and the windows repeat every 0x100 bytes. Software uses the window to enable or pause the channel and to reset its queue. It also rings the doorbell by writing a new submission tail index, acknowledges interrupt causes, and reads the channel's current state.

Each channel runs a state machine that hands one submission entry at a time to an external copy engine. The handover is a one-cycle start pulse that carries the entry index. The engine answers with a done or an error strobe. The machine then passes through a completion state or stops in an abort state, and it raises the matching interrupt cause. Data movement, bus mastering and interrupt message delivery live outside this block.

Top module: `qp_chan_ctrl`

## Requirements
- R1: After reset, for every channel: the control word, status word, state, tail and head read 0; the interrupt mask reads 0x1FFF; no irq or start is active.
- R2: Channel c sits at byte address c*0x100 plus the offset. Writes to one channel leave every other channel unchanged. Unmapped offsets (for example 0x50) read 0. Read data is valid in the cycle after the read strobe.
- R3: The control word at offset 0x20 holds enable in bit 0 and pause in bit 4. All other bits read 0.
- R4: Software writes the tail at 0x0C. If the channel is enabled, not paused, IDLE, and its tail differs from its internal fetch index, it goes to RUN one cycle after the write. It pulses start for one cycle, presents the fetch index as the entry index, and then advances the fetch index.
- R5: A done strobe in RUN moves the channel to CPL and sets status bit 0. From CPL the channel goes to RUN with the next start pulse if more entries are pending. Otherwise it goes to IDLE.
- R6: An error strobe in RUN moves the channel to ABORT and sets status bit 1. If done and error arrive together, the error takes priority and bit 0 stays clear. ABORT holds until enable is cleared or a queue reset occurs.
- R7: With pause set, a channel in RUN waits for its done strobe. It then enters PAUSE through CPL and issues no start while pause stays set. Clearing pause returns it to IDLE, and pending entries then start.
- R8: With enable cleared, the channel is IDLE one cycle later from any state, RUN included, and no status bit is set for an abandoned entry.
- R9: Writing 1 to bit 0 at offset 0x24 starts a queue reset. That bit reads 1 for one cycle and then clears itself. While it is active the state reads IDLE. It zeroes the tail, the head (offset 0x1C) and the fetch index, so the next doorbell starts at entry 0.
- R10: The 13-bit status word at 0x40 is write-one-to-clear. If a hardware set and a software clear hit the same bit in the same cycle, the set wins.
- R11: irq of a channel is a register that, one cycle later, follows the OR of status bits not masked by the mask word at 0x44 (a 1 masks).
- R12: The state field sits in bits [3:0] at 0x30, with IDLE=0, RUN=1, CPL=2, PAUSE=3, ABORT=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | CH_W+8 | Byte address: channel in the upper bits, offset in [7:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| eng_start | output | NUM_CH | One-cycle start pulse per channel |
| eng_idx | output | NUM_CH*PTR_W | Entry index per channel, valid with start |
| eng_done | input | NUM_CH | Engine finished the entry without fault |
| eng_err | input | NUM_CH | Engine reports a faulty entry |
| irq | output | NUM_CH | Per-channel interrupt, registered |

## Verification
A completion cause can be set by the engine's done strobe in the same cycle that software clears the same status bit. The bench drives a write-one-to-clear of the status word and the done strobe on the same clock edge. It then reads the status back and expects the completion bit to be set. A second collision comes from driving done and error together. That case must end in ABORT with only the error bit set. Each sweep repeats over all four channels, and the bench tracks the expected entry indices itself.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_RUN   = 4'd1,
    ST_CPL   = 4'd2,
    ST_PAUSE = 4'd3,
    ST_HALT  = 4'd4,
    ST_ABORT = 4'd5,
    ST_WAIT  = 4'd6,
    ST_BCLR  = 4'd7
  } qpc_state_e;

  localparam logic [7:0] OFF_TAIL  = 8'h0C;
  localparam logic [7:0] OFF_HEAD  = 8'h1C;
  localparam logic [7:0] OFF_CTRL  = 8'h20;
  localparam logic [7:0] OFF_QRST  = 8'h24;
  localparam logic [7:0] OFF_STATE = 8'h30;
  localparam logic [7:0] OFF_ISTS  = 8'h40;
  localparam logic [7:0] OFF_IMSK  = 8'h44;

  localparam int EN_BIT    = 0;
  localparam int PAUSE_BIT = 4;
  localparam int QRST_BIT  = 0;
endpackage

// File: rtl/qpc_chan_fsm.sv
module qpc_chan_fsm
  import qpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       pause,
  input  logic       qrst,
  input  logic       pending,
  input  logic       eng_done,
  input  logic       eng_err,
  output qpc_state_e st_q,
  output logic       start_q,
  output logic       fetch_adv,
  output logic       ev_cpl,
  output logic       ev_err
);

  qpc_state_e st_nxt;

  always_comb begin
    st_nxt    = st_q;
    fetch_adv = 1'b0;
    ev_cpl    = 1'b0;
    ev_err    = 1'b0;
    if (qrst || !en) begin
      st_nxt = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (pause) begin
            st_nxt = ST_PAUSE;
          end else if (pending) begin
            st_nxt    = ST_RUN;
            fetch_adv = 1'b1;
          end
        end
        ST_RUN: begin
          if (eng_err) begin
            st_nxt = ST_ABORT;
            ev_err = 1'b1;
          end else if (eng_done) begin
            st_nxt = ST_CPL;
            ev_cpl = 1'b1;
          end
        end
        ST_CPL: begin
          if (pause) begin
            st_nxt = ST_PAUSE;
          end else if (pending) begin
            st_nxt    = ST_RUN;
            fetch_adv = 1'b1;
          end else begin
            st_nxt = ST_IDLE;
          end
        end
        ST_PAUSE: begin
          if (!pause) st_nxt = ST_IDLE;
        end
        ST_ABORT: st_nxt = ST_ABORT;
        default:  st_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_nxt;
      start_q <= fetch_adv;
    end
  end

  // R8: disable leaves RUN at once
  assert_disable_exits_run_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && !en) |=> (st_q == ST_IDLE));

  // R6: an error strobe in RUN ends in ABORT
  assert_err_to_abort_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && en && !qrst && eng_err) |=> (st_q == ST_ABORT));

  // R7: no fetch while paused
  assert_no_start_paused_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PAUSE && pause && !qrst) |=> !start_q);

  // R9: queue reset forces IDLE
  assert_qrst_idle_R9: assert property (@(posedge clk) disable iff (rst)
    qrst |=> (st_q == ST_IDLE));

  // R5: completion with nothing pending returns to IDLE
  assert_cpl_to_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CPL && en && !qrst && !pause && !pending) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/qpc_chan.sv
module qpc_chan
  import qpc_pkg::*;
#(
  parameter int PTR_W   = 4,
  parameter int IRQ_W   = 13,
  parameter int CPL_BIT = 0,
  parameter int ERR_BIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_off,
  input  logic [31:0]      wdata,
  input  logic [7:0]       rd_off,
  input  logic             eng_done,
  input  logic             eng_err,
  output logic [31:0]      rword,
  output logic             eng_start,
  output logic [PTR_W-1:0] eng_idx,
  output logic             irq
);

  logic             en_q, pause_q, qrst_q, irq_q;
  logic [PTR_W-1:0] tail_q, head_q, fetch_q, sidx_q;
  logic [IRQ_W-1:0] status_q, mask_q, set_vec, clr_vec;
  logic             w_tail, w_head, w_ctrl, w_qrst, w_ists, w_imsk, qrst_req;
  logic             fetch_adv, ev_cpl, ev_err, pending;
  qpc_state_e       st_q, st_view;

  assign w_tail   = wr_en && (wr_off == OFF_TAIL);
  assign w_head   = wr_en && (wr_off == OFF_HEAD);
  assign w_ctrl   = wr_en && (wr_off == OFF_CTRL);
  assign w_qrst   = wr_en && (wr_off == OFF_QRST);
  assign w_ists   = wr_en && (wr_off == OFF_ISTS);
  assign w_imsk   = wr_en && (wr_off == OFF_IMSK);
  assign qrst_req = w_qrst && wdata[QRST_BIT];
  assign pending  = (tail_q != fetch_q);

  qpc_chan_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en        (en_q),
    .pause     (pause_q),
    .qrst      (qrst_q),
    .pending   (pending),
    .eng_done  (eng_done),
    .eng_err   (eng_err),
    .st_q      (st_q),
    .start_q   (eng_start),
    .fetch_adv (fetch_adv),
    .ev_cpl    (ev_cpl),
    .ev_err    (ev_err)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[CPL_BIT] = ev_cpl;
    set_vec[ERR_BIT] = ev_err;
    clr_vec          = w_ists ? wdata[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      pause_q  <= 1'b0;
      qrst_q   <= 1'b0;
      tail_q   <= '0;
      head_q   <= '0;
      fetch_q  <= '0;
      sidx_q   <= '0;
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      if (w_ctrl) begin
        en_q    <= wdata[EN_BIT];
        pause_q <= wdata[PAUSE_BIT];
      end
      qrst_q <= qrst_req;
      if (qrst_q) begin
        tail_q  <= '0;
        head_q  <= '0;
        fetch_q <= '0;
      end else begin
        if (w_tail) tail_q <= wdata[PTR_W-1:0];
        if (w_head) head_q <= wdata[PTR_W-1:0];
        if (fetch_adv) begin
          fetch_q <= fetch_q + 1'b1;
          sidx_q  <= fetch_q;
        end
      end
      status_q <= (status_q & ~clr_vec) | set_vec;
      if (w_imsk) mask_q <= wdata[IRQ_W-1:0];
      irq_q <= |(status_q & ~mask_q);
    end
  end

  assign st_view = qrst_q ? ST_IDLE : st_q;
  assign eng_idx = sidx_q;
  assign irq     = irq_q;

  always_comb begin
    case (rd_off)
      OFF_TAIL:  rword = 32'(tail_q);
      OFF_HEAD:  rword = 32'(head_q);
      OFF_CTRL:  rword = {27'd0, pause_q, 3'd0, en_q};
      OFF_QRST:  rword = {31'd0, qrst_q};
      OFF_STATE: rword = {28'd0, st_view};
      OFF_ISTS:  rword = 32'(status_q);
      OFF_IMSK:  rword = 32'(mask_q);
      default:   rword = 32'd0;
    endcase
  end

  // R9: reset request clears itself
  assert_qrst_selfclear_R9: assert property (@(posedge clk) disable iff (rst)
    (qrst_q && !qrst_req) |=> !qrst_q);

  // R9: reset zeroes the software pointers
  assert_qrst_ptrs_R9: assert property (@(posedge clk) disable iff (rst)
    qrst_q |=> (tail_q == '0 && head_q == '0));

  // R10: hardware set survives a simultaneous clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    ev_cpl |=> status_q[CPL_BIT]);

  // R11: no unmasked cause means no irq
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~mask_q) == '0) |=> !irq_q);

endmodule

// File: rtl/qpc_rd_mux.sv
module qpc_rd_mux #(
  parameter int CH_W   = 2,
  localparam int NUM_CH = 1 << CH_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd,
  input  logic [CH_W-1:0]      sel,
  input  logic [NUM_CH*32-1:0] words,
  output logic [31:0]          rdata
);

  logic [31:0] pick;

  assign pick = words[sel*32 +: 32];

  always_ff @(posedge clk) begin
    if (rst)     rdata <= 32'd0;
    else if (rd) rdata <= pick;
  end

endmodule

// File: rtl/qp_chan_ctrl.sv
module qp_chan_ctrl
  import qpc_pkg::*;
#(
  parameter int CH_W   = 2,
  parameter int PTR_W  = 4,
  parameter int IRQ_W  = 13,
  localparam int NUM_CH = 1 << CH_W,
  localparam int ADDR_W = CH_W + 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic [NUM_CH-1:0]       eng_start,
  output logic [NUM_CH*PTR_W-1:0] eng_idx,
  input  logic [NUM_CH-1:0]       eng_done,
  input  logic [NUM_CH-1:0]       eng_err,
  output logic [NUM_CH-1:0]       irq
);

  logic [NUM_CH*32-1:0] words;
  logic [CH_W-1:0]      ch_sel;

  assign ch_sel = reg_addr[ADDR_W-1:8];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    qpc_chan #(
      .PTR_W   (PTR_W),
      .IRQ_W   (IRQ_W),
      .CPL_BIT (0),
      .ERR_BIT (1)
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (reg_wr && (ch_sel == CH_W'(g))),
      .wr_off    (reg_addr[7:0]),
      .wdata     (reg_wdata),
      .rd_off    (reg_addr[7:0]),
      .eng_done  (eng_done[g]),
      .eng_err   (eng_err[g]),
      .rword     (words[g*32 +: 32]),
      .eng_start (eng_start[g]),
      .eng_idx   (eng_idx[g*PTR_W +: PTR_W]),
      .irq       (irq[g])
    );
  end

  qpc_rd_mux #(.CH_W(CH_W)) u_rd_mux (
    .clk   (clk),
    .rst   (rst),
    .rd    (reg_rd),
    .sel   (ch_sel),
    .words (words),
    .rdata (reg_rdata)
  );

endmodule

// File: tb/test_qp_chan_ctrl.sv
module test_qp_chan_ctrl;
  localparam int CH_W = 2, PTR_W = 4, NCH = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [CH_W+7:0]   reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NCH-1:0]    eng_start, eng_done = '0, eng_err = '0, irq;
  logic [NCH*PTR_W-1:0] eng_idx;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  qp_chan_ctrl #(.CH_W(CH_W), .PTR_W(PTR_W), .IRQ_W(13)) i_qp_chan_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
    .eng_idx(eng_idx), .eng_done(eng_done), .eng_err(eng_err), .irq(irq)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(int ch, logic [7:0] off, logic [31:0] d);
    reg_addr = {2'(ch), off}; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(int ch, logic [7:0] off, output logic [31:0] d);
    reg_addr = {2'(ch), off}; reg_rd = 1'b1;
    tick();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic strobe(int ch, bit dn, bit er);
    eng_done[ch] = dn; eng_err[ch] = er;
    tick();
    eng_done[ch] = 1'b0; eng_err[ch] = 1'b0;
  endtask

  task automatic chk_start(string req, int ch, bit exp_s, int exp_i);
    chk(req, 32'(eng_start), exp_s ? (32'd1 << ch) : 32'd0);
    if (exp_s) chk(req, 32'(eng_idx[ch*PTR_W +: PTR_W]), 32'(exp_i));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tick();
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 start", 32'(eng_start), 32'd0);

    for (int ch = 0; ch < NCH; ch++) begin
      // R1 reset values, untouched by earlier channels (R2)
      rd(ch, 8'h20, v); chk("R1 ctrl", v, 32'd0);
      rd(ch, 8'h30, v); chk("R1 state", v, 32'd0);
      rd(ch, 8'h44, v); chk("R1 mask", v, 32'h1FFF);
      rd(ch, 8'h40, v); chk("R1 status", v, 32'd0);
      rd(ch, 8'h0C, v); chk("R1 tail", v, 32'd0);
      rd(ch, 8'h1C, v); chk("R1 head", v, 32'd0);

      // R3 control bits
      wr(ch, 8'h20, 32'hFFFF_FFFF);
      rd(ch, 8'h20, v); chk("R3 ctrl all ones", v, 32'h11);
      wr(ch, 8'h20, 32'h1);
      rd(ch, 8'h20, v); chk("R3 ctrl enable", v, 32'h1);
      if (ch < NCH - 1) begin
        rd(ch + 1, 8'h20, v); chk("R2 neighbour ctrl", v, 32'd0);
      end
      rd(ch, 8'h50, v); chk("R2 unmapped", v, 32'd0);

      // R4 doorbell
      wr(ch, 8'h0C, 32'd1);
      chk_start("R4 no early start", ch, 1'b0, 0);
      tick(); chk_start("R4 start", ch, 1'b1, 0);
      tick(); chk_start("R4 single pulse", ch, 1'b0, 0);
      rd(ch, 8'h30, v); chk("R4 R12 state RUN", v, 32'd1);

      // R5 completion
      strobe(ch, 1'b1, 1'b0);
      rd(ch, 8'h30, v); chk("R5 R12 state CPL", v, 32'd2);
      rd(ch, 8'h30, v); chk("R5 state IDLE", v, 32'd0);
      rd(ch, 8'h40, v); chk("R5 status cpl", v, 32'd1);
      chk("R11 masked irq", 32'(irq[ch]), 32'd0);

      // R11 / R10
      wr(ch, 8'h44, 32'd0);
      tick(); chk("R11 irq raised", 32'(irq[ch]), 32'd1);
      wr(ch, 8'h40, 32'd1);
      tick(); chk("R11 irq dropped", 32'(irq[ch]), 32'd0);
      rd(ch, 8'h40, v); chk("R10 w1c", v, 32'd0);

      // R5 back-to-back entries
      wr(ch, 8'h0C, 32'd3);
      tick(); chk_start("R5 start idx1", ch, 1'b1, 1);
      strobe(ch, 1'b1, 1'b0);
      tick(); chk_start("R5 CPL to RUN idx2", ch, 1'b1, 2);
      strobe(ch, 1'b1, 1'b0);
      tick();
      rd(ch, 8'h30, v); chk("R5 drained IDLE", v, 32'd0);

      // R6 error wins over done
      wr(ch, 8'h40, 32'h1FFF);
      wr(ch, 8'h0C, 32'd4);
      tick(); chk_start("R6 start idx3", ch, 1'b1, 3);
      strobe(ch, 1'b1, 1'b1);
      rd(ch, 8'h40, v); chk("R6 err status", v, 32'd2);
      rd(ch, 8'h30, v); chk("R6 R12 ABORT", v, 32'd5);
      tick(); tick(); tick();
      rd(ch, 8'h30, v); chk("R6 ABORT held", v, 32'd5);
      chk("R11 err irq", 32'(irq[ch]), 32'd1);
      wr(ch, 8'h20, 32'd0);
      tick();
      rd(ch, 8'h30, v); chk("R8 ABORT to IDLE", v, 32'd0);

      // R7 pause
      wr(ch, 8'h40, 32'h1FFF);
      wr(ch, 8'h20, 32'd1);
      wr(ch, 8'h0C, 32'd5);
      tick(); chk_start("R7 start idx4", ch, 1'b1, 4);
      wr(ch, 8'h20, 32'h11);
      tick(); tick();
      rd(ch, 8'h30, v); chk("R7 RUN kept", v, 32'd1);
      strobe(ch, 1'b1, 1'b0);
      tick();
      wr(ch, 8'h0C, 32'd6);
      tick(); chk_start("R7 no start", ch, 1'b0, 0);
      tick(); chk_start("R7 no start", ch, 1'b0, 0);
      rd(ch, 8'h30, v); chk("R7 R12 PAUSE", v, 32'd3);
      wr(ch, 8'h20, 32'd1);
      chk_start("R7 unpause", ch, 1'b0, 0);
      tick(); chk_start("R7 via IDLE", ch, 1'b0, 0);
      tick(); chk_start("R7 resume idx5", ch, 1'b1, 5);

      // R8 pause set and enable cleared during RUN
      wr(ch, 8'h40, 32'h1FFF);
      wr(ch, 8'h20, 32'h10);
      tick();
      rd(ch, 8'h30, v); chk("R8 RUN left", v, 32'd0);
      rd(ch, 8'h40, v); chk("R8 no event", v, 32'd0);

      // R9 queue reset
      wr(ch, 8'h1C, 32'd3);
      wr(ch, 8'h20, 32'd1);
      wr(ch, 8'h0C, 32'd7);
      tick(); chk_start("R9 start idx6", ch, 1'b1, 6);
      strobe(ch, 1'b0, 1'b1);
      wr(ch, 8'h24, 32'd1);
      rd(ch, 8'h30, v); chk("R9 state forced IDLE", v, 32'd0);
      rd(ch, 8'h0C, v); chk("R9 tail zero", v, 32'd0);
      rd(ch, 8'h1C, v); chk("R9 head zero", v, 32'd0);
      wr(ch, 8'h24, 32'd1);
      rd(ch, 8'h24, v); chk("R9 reset bit set", v, 32'd1);
      rd(ch, 8'h24, v); chk("R9 reset self-clear", v, 32'd0);
      rd(ch, 8'h30, v); chk("R9 IDLE after", v, 32'd0);
      tick(); chk_start("R9 nothing pending", ch, 1'b0, 0);
      wr(ch, 8'h0C, 32'd1);
      tick(); chk_start("R9 restart idx0", ch, 1'b1, 0);

      // R10 collision: done and W1C on the same edge
      wr(ch, 8'h40, 32'h1FFF);
      reg_addr = {2'(ch), 8'h40}; reg_wdata = 32'h3; reg_wr = 1'b1;
      eng_done[ch] = 1'b1;
      tick();
      reg_wr = 1'b0; eng_done[ch] = 1'b0;
      rd(ch, 8'h40, v); chk("R10 set wins", v, 32'd1);

      wr(ch, 8'h40, 32'h1FFF);
      wr(ch, 8'h44, 32'h1FFF);
      wr(ch, 8'h20, 32'd0);
      tick();
      chk("R2 R11 irq quiet", 32'(irq), 32'd0);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule